// File: doc/BRIEF.md
# Destructive-Read Core Word Store Controller

This block models a word store built from magnetic cores selected by coincident currents, and it runs the access cycles that such a store needs. The words are held in register bit planes inside the block, one plane for each data bit. Every plane shares the same one-hot X and Y select lines, and each plane returns its own sense bit. A host starts an access with a valid/ready handshake. The host supplies an address, a write flag and write data, and it receives a read data word.

Sensing a core also clears it. Because of this, every access has two phases. First a clear phase drives the addressed core of every plane to zero and captures whether each core held a one. Then a set phase drives the same cores toward one, and it holds at zero, through per-plane inhibit lines, every bit whose target value is zero. For a host read, the set phase puts the sensed word back. For a host write, the set phase stores the new word and the sensed word is discarded from storage.

Top module: `core_mem_top`

## Requirements
- R1: The address is split with bits [X_BITS-1:0] as the X line index and the bits above as the Y line index. While the clear or set phase is active, exactly one X line and exactly one Y line are high, so every address reaches its own word.
- R2: An access changes only the word at the selected crossing, and all other addresses keep their contents.
- R3: A write stores reqWdata at reqAddr, and a later read of that address returns it.
- R4: A read returns the stored word and restores it, so two reads of the same address in a row return identical data. Each clear phase is followed, two cycles later, by a set phase.
- R5: For a write access, rdData returns the word the address held before the write.
- R6: Zero bits are written by inhibiting the set drive. Inhibit lines are high only in the set phase, and only for planes whose target bit is zero. Writing 0x00 over 0xFF leaves 0x00.
- R7: A request is accepted on a clock edge where reqValid and reqReady are both high. reqReady is then low for exactly three cycles and rises together with the new rdData.
- R8: rdData holds its value until the next request is accepted.
- R9: Outside the clear and set phases, all select lines are low. While reqValid is low, changes on reqAddr, reqWrite and reqWdata have no effect on the stored words.
- R10: The stored words are kept through idle periods and through reset, because reset does not clear the bit planes.
- R11: After reset, reqReady is 1 and rdData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the control state and output register |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | X_BITS+Y_BITS | Word address: X index in the low bits, Y index above it |
| reqWrite | input | 1 | 1 = store reqWdata, 0 = read |
| reqWdata | input | WIDTH | Word to store on a write |
| rdData | output | WIDTH | Sensed word of the last completed access |

## Verification
The properties assume that reqValid is never X after reset, and that a request is taken only on an edge where reqReady is high. They do not assume that reqValid stays low while the block is busy. The bench drives every input half a cycle away from the sampling edge, raises reqValid only after it has seen reqReady high, and drops it after one accepting edge. Before the bench relies on any old contents, it writes every address, because the bit planes have no reset value.

// File: rtl/core_mem_pkg.sv
package core_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_LATCH,
    ST_SET,
    ST_DONE
  } cycState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic accept;    // capture request fields
    logic clearEn;   // clear phase: select, sense, clear
    logic wordLoad;  // choose word for the set phase
    logic setEn;     // set phase: select, drive toward one, inhibit zeros
    logic outLoad;   // present sensed word to host
  } coreStb_t;

endpackage

// File: rtl/core_sel_decode.sv
module core_sel_decode #(
  parameter int IDX_BITS = 3,
  localparam int LINES = 1 << IDX_BITS
) (
  input  logic                en,
  input  logic [IDX_BITS-1:0] idx,
  output logic [LINES-1:0]    lines
);

  always_comb begin
    lines = '0;
    if (en) lines[idx] = 1'b1;
  end

endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_mem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  output logic     reqReady,
  output coreStb_t stb
);

  cycState_t state, stateNext;
  logic accept;

  assign reqReady = (state == ST_IDLE) || (state == ST_DONE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE,
      ST_DONE:  stateNext = accept ? ST_CLEAR : ST_IDLE;
      ST_CLEAR: stateNext = ST_LATCH;
      ST_LATCH: stateNext = ST_SET;
      ST_SET:   stateNext = ST_DONE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stb          = '0;
    stb.accept   = accept;
    stb.clearEn  = (state == ST_CLEAR);
    stb.wordLoad = (state == ST_LATCH);
    stb.setEn    = (state == ST_SET);
    stb.outLoad  = (state == ST_SET);
  end

endmodule

// File: rtl/core_array.sv
module core_array
  import core_mem_pkg::*;
#(
  parameter int X_BITS = 3,
  parameter int Y_BITS = 3,
  parameter int WIDTH  = 8,
  localparam int XN     = 1 << X_BITS,
  localparam int YN     = 1 << Y_BITS,
  localparam int WORDS  = XN * YN,
  localparam int ADDR_W = X_BITS + Y_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  coreStb_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [WIDTH-1:0]  reqWdata,
  output logic [XN-1:0]     xSel,
  output logic [YN-1:0]     ySel,
  output logic [WIDTH-1:0]  inhibit,
  output logic [WIDTH-1:0]  senseBus,
  output logic [WIDTH-1:0]  rdData
);

  logic [ADDR_W-1:0] addrReg;
  logic              writeReg;
  logic [WIDTH-1:0]  wdataReg;
  logic [WIDTH-1:0]  senseReg;
  logic [WIDTH-1:0]  wordReg;
  logic [WORDS-1:0]  hit;
  logic              selEn;

  // request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrReg  <= '0;
      writeReg <= 1'b0;
      wdataReg <= '0;
    end else if (stb.accept) begin
      addrReg  <= reqAddr;
      writeReg <= reqWrite;
      wdataReg <= reqWdata;
    end
  end

  assign selEn = stb.clearEn | stb.setEn;

  core_sel_decode #(.IDX_BITS(X_BITS)) i_xDec (
    .en   (selEn),
    .idx  (addrReg[X_BITS-1:0]),
    .lines(xSel)
  );

  core_sel_decode #(.IDX_BITS(Y_BITS)) i_yDec (
    .en   (selEn),
    .idx  (addrReg[ADDR_W-1:X_BITS]),
    .lines(ySel)
  );

  // coincidence of one X and one Y line
  for (genvar gy = 0; gy < YN; gy++) begin : g_row
    for (genvar gx = 0; gx < XN; gx++) begin : g_col
      assign hit[gy*XN + gx] = xSel[gx] & ySel[gy];
    end
  end

  assign inhibit = stb.setEn ? ~wordReg : '0;

  // one bit plane per data bit, no reset: contents persist
  for (genvar gp = 0; gp < WIDTH; gp++) begin : g_plane
    logic [WORDS-1:0] cores;

    always_ff @(posedge clk) begin
      for (int w = 0; w < WORDS; w++) begin
        if (hit[w]) begin
          if (stb.clearEn)                    cores[w] <= 1'b0;
          else if (stb.setEn && !inhibit[gp]) cores[w] <= 1'b1;
        end
      end
    end

    assign senseBus[gp] = |(cores & hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      senseReg <= '0;
      wordReg  <= '0;
      rdData   <= '0;
    end else begin
      if (stb.clearEn)  senseReg <= senseBus;
      if (stb.wordLoad) wordReg  <= writeReg ? wdataReg : senseReg;
      if (stb.outLoad)  rdData   <= senseReg;
    end
  end

endmodule

// File: rtl/core_mem_top.sv
module core_mem_top
  import core_mem_pkg::*;
#(
  parameter int X_BITS = 3,
  parameter int Y_BITS = 3,
  parameter int WIDTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [X_BITS+Y_BITS-1:0] reqAddr,
  input  logic                     reqWrite,
  input  logic [WIDTH-1:0]         reqWdata,
  output logic [WIDTH-1:0]         rdData
);

  localparam int XN = 1 << X_BITS;
  localparam int YN = 1 << Y_BITS;

  coreStb_t         stb;
  logic [XN-1:0]    xSel;
  logic [YN-1:0]    ySel;
  logic [WIDTH-1:0] inhibit;
  logic [WIDTH-1:0] senseBus;
  logic             clearPhase;
  logic             setPhase;

  core_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .stb     (stb)
  );

  core_array #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .WIDTH(WIDTH)) i_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .reqAddr (reqAddr),
    .reqWrite(reqWrite),
    .reqWdata(reqWdata),
    .xSel    (xSel),
    .ySel    (ySel),
    .inhibit (inhibit),
    .senseBus(senseBus),
    .rdData  (rdData)
  );

  assign clearPhase = stb.clearEn;
  assign setPhase   = stb.setEn;

endmodule

// File: rtl/core_mem_chk.sv
module core_mem_chk #(
  parameter int X_BITS = 3,
  parameter int Y_BITS = 3,
  parameter int WIDTH  = 8,
  localparam int XN = 1 << X_BITS,
  localparam int YN = 1 << Y_BITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic [WIDTH-1:0] rdData,
  input logic [XN-1:0]    xSel,
  input logic [YN-1:0]    ySel,
  input logic [WIDTH-1:0] inhibit,
  input logic             clearPhase,
  input logic             setPhase
);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (clearPhase || setPhase) |-> ($onehot(xSel) && $onehot(ySel))); // R1

  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(clearPhase || setPhase) |-> (xSel == '0 && ySel == '0)); // R9

  AST_INHIBIT_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !setPhase |-> (inhibit == '0)); // R6

  AST_RESTORE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    clearPhase |=> ##1 setPhase); // R4

  AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady ##1 !reqReady ##1 !reqReady ##1 reqReady); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && $past(reqReady)) |-> $stable(rdData)); // R8

endmodule

bind core_mem_top core_mem_chk #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .WIDTH(WIDTH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .rdData    (rdData),
  .xSel      (xSel),
  .ySel      (ySel),
  .inhibit   (inhibit),
  .clearPhase(clearPhase),
  .setPhase  (setPhase)
);

// File: tb/test_core_mem_top.sv
module test_core_mem_top;

  localparam int X_BITS = 3;
  localparam int Y_BITS = 3;
  localparam int WIDTH  = 8;
  localparam int ADDR_W = X_BITS + Y_BITS;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic [WIDTH-1:0]  reqWdata = '0;
  logic [WIDTH-1:0]  rdData;

  always #5ns clk = ~clk;

  core_mem_top #(.X_BITS(X_BITS), .Y_BITS(Y_BITS), .WIDTH(WIDTH)) i_core_mem_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqAddr (reqAddr),
    .reqWrite(reqWrite),
    .reqWdata(reqWdata),
    .rdData  (rdData)
  );

  typedef struct {
    logic [WIDTH-1:0] val;
    bit               doChk;
    string            tag;
  } expItem_t;

  expItem_t         expQ[$];
  logic [WIDTH-1:0] refMem [WORDS];
  logic [WIDTH-1:0] lastExp;
  int               vectors = 0;
  int               miscompares = 0;
  int               lowCnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver: push expectation, then hand the request over
  task automatic access(input logic [ADDR_W-1:0] a, input bit wr,
                        input logic [WIDTH-1:0] d, input bit doChk, input string tag);
    expItem_t it;
    it.val   = refMem[a];
    it.doChk = doChk;
    it.tag   = tag;
    if (wr) refMem[a] = d;
    lastExp = it.val;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expQ.push_back(it);
    reqValid = 1'b1;
    reqAddr  = a;
    reqWrite = wr;
    reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: measures the busy window and compares returned words
  always @(negedge clk) begin
    if (!rst_n) begin
      lowCnt = 0;
    end else if (!reqReady) begin
      lowCnt++;
    end else if (lowCnt != 0) begin
      expItem_t it;
      check(lowCnt == 3, "R7 busy cycles", lowCnt, 3);
      lowCnt = 0;
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected completion", 0, 1);
      end else begin
        it = expQ.pop_front();
        if (it.doChk) check(rdData === it.val, it.tag, int'(rdData), int'(it.val));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(reqReady === 1'b1, "R11 ready in reset", int'(reqReady), 1);
    check(rdData === '0, "R11 rdData in reset", int'(rdData), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1, "R11 ready after reset", int'(reqReady), 1);

    // R1 R3: fill every address, old contents unknown
    for (int a = 0; a < WORDS; a++)
      access(ADDR_W'(a), 1'b1, WIDTH'(a * 29 + 7), 1'b0, "R3 fill");
    for (int a = 0; a < WORDS; a++)
      access(ADDR_W'(a), 1'b0, '0, 1'b1, "R1 R3 read after fill");
    drain();

    // R4: repeated reads return the same word
    access(6'd9, 1'b0, '0, 1'b1, "R4 first read");
    access(6'd9, 1'b0, '0, 1'b1, "R4 second read");
    access(6'd9, 1'b0, '0, 1'b1, "R4 third read");

    // R5: write returns previous contents
    access(6'd9, 1'b1, 8'hA5, 1'b1, "R5 old word on write");
    access(6'd9, 1'b0, '0, 1'b1, "R3 read new word");

    // R6: zeros by inhibit
    access(6'd20, 1'b1, 8'hFF, 1'b1, "R5 old word on write");
    access(6'd20, 1'b1, 8'h00, 1'b1, "R6 old ones sensed");
    access(6'd20, 1'b0, '0, 1'b1, "R6 zeros stored");
    access(6'd20, 1'b1, 8'h5A, 1'b1, "R6 zero word sensed");
    access(6'd20, 1'b0, '0, 1'b1, "R6 mixed word");

    // R2: neighbours along X and along Y untouched
    access(6'd0, 1'b1, 8'h3C, 1'b1, "R5 old word on write");
    access(6'd1, 1'b0, '0, 1'b1, "R2 X neighbour");
    access(6'd8, 1'b0, '0, 1'b1, "R2 Y neighbour");
    access(6'd9, 1'b0, '0, 1'b1, "R2 diagonal neighbour");
    access(6'd0, 1'b0, '0, 1'b1, "R2 target word");
    drain();

    // R8: rdData held while idle
    repeat (10) @(negedge clk);
    check(rdData === lastExp, "R8 rdData held", int'(rdData), int'(lastExp));

    // R9: input changes without reqValid
    for (int i = 0; i < 20; i++) begin
      reqAddr  = ADDR_W'(i * 5);
      reqWrite = 1'b1;
      reqWdata = WIDTH'(i * 13 + 1);
      @(negedge clk);
    end
    reqWrite = 1'b0;
    check(rdData === lastExp, "R8 rdData held after wiggle", int'(rdData), int'(lastExp));
    for (int i = 0; i < 20; i++)
      access(ADDR_W'(i * 5), 1'b0, '0, 1'b1, "R9 no write without valid");
    drain();

    // R10: idle and reset keep contents
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(rdData === '0, "R11 rdData after second reset", int'(rdData), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < WORDS; a++)
      access(ADDR_W'(a), 1'b0, '0, 1'b1, "R10 retained");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule